// File: doc/BRIEF.md
# Nibble-Readable Byte-Code Decoder

This block is the front-end decoder of a byte-stream processor whose opcodes are meant to be read straight from a hex dump. Each byte is made of two nibbles. A decimal digit (0–9) is an index or a value. A letter (A–F) is a group or an operation code. The decoder takes one fetched byte per strobe and sorts it into a class. It keeps three pieces of context from byte to byte: the chosen receiver register, the active pair of operand groups and a pending decimal prefix.

Bytes that complete an instruction produce one registered, decoded record with a single-cycle valid pulse. These are halt, ALU operation, conditional return and extended call. Bytes that only shape the context produce no record: register select, group pair and prefix. Execution, memory access and flag evaluation belong to later stages.

Top module: `nbd_decoder`

## Requirements
- R1: Byte 0x00 completes a halt record (op_kind 0).
- R2: A byte with both nibbles in 0–9 other than 0x00 is latched as the pending prefix and produces no record.
- R3: A byte with high nibble 0–9 and low nibble A–F completes an ALU record (op_kind 1). Its low nibble gives alu_op: A=0 add, B=1 subtract, C=2 and, D=3 or, E=4 xor, F=5 move. Its high nibble is the translator index. The receiver and translator groups come from the context. Group codes are A=0, B=1, C=2, D=3.
- R4: A byte with high nibble A–D and low nibble 0–9 sets the receiver group and index. Of several such bytes in a row, only the last one counts, and none of them produces a record.
- R5: A byte with both nibbles in A–D sets the receiver group from its high nibble and the translator group from its low nibble. The receiver index is left as it was.
- R6: Bytes 0xAE, 0xAF, 0xBE, 0xBF, 0xCE and 0xCF complete a conditional-return record (op_kind 2). Their cond codes are 0 to 5 in that order: zero set, zero clear, sign set, sign clear, carry set, carry clear.
- R7: Bytes 0xE0–0xFF complete a call record (op_kind 3) whose target is the byte value times 256.
- R8: When a record is completed while a prefix is pending, the record carries mem_ref=1 and offset equal to the prefix, and the prefix is then cleared. Without a pending prefix, mem_ref=0 and offset=0.
- R9: Bytes 0xDE and 0xDF are illegal. So is any prefix, select or pair byte that arrives while a prefix is pending. An illegal byte raises illegal for one cycle, produces no record and leaves all context unchanged, including the pending prefix.
- R10: op_vld and illegal pulse in the single cycle after the byte strobe. Without a strobe, the record outputs hold their values.
- R11: After reset no prefix is pending, the receiver is A0, the translator group is A, and op_vld and illegal are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld_i | input | 1 | Byte strobe |
| byte_i | input | 8 | Fetched byte |
| op_vld_o | output | 1 | Record completed (one-cycle pulse) |
| illegal_o | output | 1 | Illegal byte seen (one-cycle pulse) |
| op_kind_o | output | 2 | 0 halt, 1 ALU, 2 conditional return, 3 call |
| alu_op_o | output | 3 | ALU operation code |
| rcv_grp_o | output | 2 | Receiver group |
| rcv_idx_o | output | 4 | Receiver index |
| trn_grp_o | output | 2 | Translator group |
| trn_idx_o | output | 4 | Translator index |
| mem_ref_o | output | 1 | Operand is a memory reference from a prefix |
| offset_o | output | 8 | Prefix value used as the offset |
| cond_o | output | 3 | Conditional-return test code |
| target_o | output | 16 | Call target address |

## Verification
Byte sequences exercise each class both from the reset context and after the context has been built up by select, pair and prefix bytes. This shows whether a field comes from the current byte or from the stored context. Runs of select bytes separate a design that keeps only the last select from one that mixes earlier ones in. Prefix-then-record pairs, followed by a second record without a prefix, show both that the prefix is consumed and that it is cleared. Illegal bytes are each followed by an ALU byte, which makes the unchanged context, including a still-pending prefix, visible on the ports.

// File: rtl/nbd_pkg.sv
package nbd_pkg;
    typedef enum logic [1:0] {NK_DIG, NK_AD, NK_EF} nib_kind_e;
    typedef enum logic [2:0] {
        BC_HALT, BC_PREFIX, BC_ALU, BC_SELECT, BC_PAIR, BC_CRET, BC_CALL, BC_BAD
    } byte_class_e;
    localparam logic [1:0] KIND_HALT = 2'd0;
    localparam logic [1:0] KIND_ALU  = 2'd1;
    localparam logic [1:0] KIND_CRET = 2'd2;
    localparam logic [1:0] KIND_CALL = 2'd3;
endpackage

// File: rtl/nbd_nibble.sv
module nbd_nibble
    import nbd_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic [NIB_W-1:0] nib_i,
    output nib_kind_e        kind_o
);
    always_comb begin
        if (nib_i <= NIB_W'(9))       kind_o = NK_DIG;
        else if (nib_i <= NIB_W'(13)) kind_o = NK_AD;
        else                          kind_o = NK_EF;
    end
endmodule

// File: rtl/nbd_classify.sv
module nbd_classify
    import nbd_pkg::*;
#(
    parameter int NIB_W = 4,
    localparam int BYTE_W = 2 * NIB_W
) (
    input  logic [BYTE_W-1:0] byte_i,
    output byte_class_e       cls_o
);
    nib_kind_e kind [2];

    for (genvar g = 0; g < 2; g++) begin : g_nib
        nbd_nibble #(.NIB_W(NIB_W)) u_nib (
            .nib_i  (byte_i[g*NIB_W +: NIB_W]),
            .kind_o (kind[g])
        );
    end

    logic [NIB_W-1:0] hi;
    assign hi = byte_i[BYTE_W-1 -: NIB_W];

    always_comb begin
        cls_o = BC_BAD;
        if (byte_i == '0)                               cls_o = BC_HALT;
        else if (kind[1] == NK_DIG && kind[0] == NK_DIG) cls_o = BC_PREFIX;
        else if (kind[1] == NK_DIG)                      cls_o = BC_ALU;
        else if (kind[1] == NK_AD && kind[0] == NK_DIG)  cls_o = BC_SELECT;
        else if (kind[1] == NK_AD && kind[0] == NK_AD)   cls_o = BC_PAIR;
        else if (kind[1] == NK_AD)
            cls_o = (hi == NIB_W'(13)) ? BC_BAD : BC_CRET;
        else                                             cls_o = BC_CALL;
    end
endmodule

// File: rtl/nbd_decoder.sv
module nbd_decoder
    import nbd_pkg::*;
#(
    parameter int NIB_W  = 4,
    parameter int ADDR_W = 16,
    localparam int BYTE_W = 2 * NIB_W,
    localparam int GRP_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              op_vld_o,
    output logic              illegal_o,
    output logic [1:0]        op_kind_o,
    output logic [2:0]        alu_op_o,
    output logic [GRP_W-1:0]  rcv_grp_o,
    output logic [NIB_W-1:0]  rcv_idx_o,
    output logic [GRP_W-1:0]  trn_grp_o,
    output logic [NIB_W-1:0]  trn_idx_o,
    output logic              mem_ref_o,
    output logic [BYTE_W-1:0] offset_o,
    output logic [2:0]        cond_o,
    output logic [ADDR_W-1:0] target_o
);
    typedef struct packed {
        logic [GRP_W-1:0]  rcv_grp;
        logic [NIB_W-1:0]  rcv_idx;
        logic [GRP_W-1:0]  trn_grp;
        logic              pend;
        logic [BYTE_W-1:0] pval;
    } ctx_t;

    typedef struct packed {
        logic              vld;
        logic              ill;
        logic [1:0]        kind;
        logic [2:0]        alu_op;
        logic [GRP_W-1:0]  rg;
        logic [NIB_W-1:0]  ri;
        logic [GRP_W-1:0]  tg;
        logic [NIB_W-1:0]  ti;
        logic              mem;
        logic [BYTE_W-1:0] off;
        logic [2:0]        cond;
        logic [ADDR_W-1:0] tgt;
    } rec_t;

    typedef struct packed {
        ctx_t ctx;
        rec_t rec;
    } state_t;

    state_t      state_d, state_q;
    byte_class_e cls;
    logic [NIB_W-1:0] hi, lo;
    logic [NIB_W-1:0] hi_grp, lo_grp;

    assign hi     = byte_i[BYTE_W-1 -: NIB_W];
    assign lo     = byte_i[NIB_W-1:0];
    assign hi_grp = hi - NIB_W'(10);
    assign lo_grp = lo - NIB_W'(10);

    nbd_classify #(.NIB_W(NIB_W)) u_classify (
        .byte_i (byte_i),
        .cls_o  (cls)
    );

    always_comb begin
        state_d         = state_q;
        state_d.rec.vld = 1'b0;
        state_d.rec.ill = 1'b0;
        if (byte_vld_i) begin
            unique case (cls)
                BC_PREFIX: begin
                    if (state_q.ctx.pend) state_d.rec.ill = 1'b1;
                    else begin
                        state_d.ctx.pend = 1'b1;
                        state_d.ctx.pval = byte_i;
                    end
                end
                BC_SELECT: begin
                    if (state_q.ctx.pend) state_d.rec.ill = 1'b1;
                    else begin
                        state_d.ctx.rcv_grp = hi_grp[GRP_W-1:0];
                        state_d.ctx.rcv_idx = lo;
                    end
                end
                BC_PAIR: begin
                    if (state_q.ctx.pend) state_d.rec.ill = 1'b1;
                    else begin
                        state_d.ctx.rcv_grp = hi_grp[GRP_W-1:0];
                        state_d.ctx.trn_grp = lo_grp[GRP_W-1:0];
                    end
                end
                BC_BAD: state_d.rec.ill = 1'b1;
                default: begin
                    state_d.rec.vld    = 1'b1;
                    state_d.rec.rg     = state_q.ctx.rcv_grp;
                    state_d.rec.ri     = state_q.ctx.rcv_idx;
                    state_d.rec.tg     = state_q.ctx.trn_grp;
                    state_d.rec.ti     = '0;
                    state_d.rec.alu_op = '0;
                    state_d.rec.cond   = '0;
                    state_d.rec.tgt    = '0;
                    state_d.rec.mem    = state_q.ctx.pend;
                    state_d.rec.off    = state_q.ctx.pend ? state_q.ctx.pval : '0;
                    state_d.ctx.pend   = 1'b0;
                    state_d.ctx.pval   = '0;
                    case (cls)
                        BC_ALU: begin
                            state_d.rec.kind   = KIND_ALU;
                            state_d.rec.alu_op = lo_grp[2:0];
                            state_d.rec.ti     = hi;
                        end
                        BC_CRET: begin
                            state_d.rec.kind = KIND_CRET;
                            state_d.rec.cond = {hi_grp[1:0], lo[0]};
                        end
                        BC_CALL: begin
                            state_d.rec.kind = KIND_CALL;
                            state_d.rec.tgt  = ADDR_W'(byte_i) << (ADDR_W - BYTE_W);
                        end
                        default: state_d.rec.kind = KIND_HALT;
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign op_vld_o  = state_q.rec.vld;
    assign illegal_o = state_q.rec.ill;
    assign op_kind_o = state_q.rec.kind;
    assign alu_op_o  = state_q.rec.alu_op;
    assign rcv_grp_o = state_q.rec.rg;
    assign rcv_idx_o = state_q.rec.ri;
    assign trn_grp_o = state_q.rec.tg;
    assign trn_idx_o = state_q.rec.ti;
    assign mem_ref_o = state_q.rec.mem;
    assign offset_o  = state_q.rec.off;
    assign cond_o    = state_q.rec.cond;
    assign target_o  = state_q.rec.tgt;

    AST_PREFIX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_i && cls == BC_PREFIX) |=> !op_vld_o); // R2
    AST_CALL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld_o && op_kind_o == KIND_CALL) |-> (target_o[BYTE_W-1:0] == '0 && target_o[ADDR_W-1 -: 3] == 3'b111)); // R7
    AST_OFFSET_DECIMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld_o && mem_ref_o) |-> (offset_o != '0 && offset_o[BYTE_W-1 -: NIB_W] <= NIB_W'(9) && offset_o[NIB_W-1:0] <= NIB_W'(9))); // R8
    AST_ILLEGAL_KEEPS_CTX: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (state_q.ctx == $past(state_q.ctx))); // R9
    AST_PULSE_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld_o || illegal_o) |-> $past(byte_vld_i)); // R10
    AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_vld_o && illegal_o)); // R9
endmodule

// File: tb/nbd_decoder_bench.sv
module nbd_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_vld_i = 1'b0;
    logic [7:0]  byte_i = '0;
    logic        op_vld_o, illegal_o, mem_ref_o;
    logic [1:0]  op_kind_o, rcv_grp_o, trn_grp_o;
    logic [2:0]  alu_op_o, cond_o;
    logic [3:0]  rcv_idx_o, trn_idx_o;
    logic [7:0]  offset_o;
    logic [15:0] target_o;
    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #10 clk = ~clk;

    nbd_decoder u_nbd_decoder (
        .clk(clk), .rst_n(rst_n), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
        .op_vld_o(op_vld_o), .illegal_o(illegal_o), .op_kind_o(op_kind_o),
        .alu_op_o(alu_op_o), .rcv_grp_o(rcv_grp_o), .rcv_idx_o(rcv_idx_o),
        .trn_grp_o(trn_grp_o), .trn_idx_o(trn_idx_o), .mem_ref_o(mem_ref_o),
        .offset_o(offset_o), .cond_o(cond_o), .target_o(target_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        byte_vld_i = 1'b1;
        byte_i     = b;
        @(negedge clk);
        byte_vld_i = 1'b0;
    endtask

    task automatic chk_alu(input string req, input logic [1:0] rg, input logic [3:0] ri,
                           input logic [1:0] tg, input logic [3:0] ti, input logic [2:0] op,
                           input logic mem, input logic [7:0] off);
        chk({req, " vld"}, op_vld_o, 1);
        chk({req, " kind"}, op_kind_o, 1);
        chk({req, " rcv"}, {rcv_grp_o, rcv_idx_o}, {rg, ri});
        chk({req, " trn"}, {trn_grp_o, trn_idx_o}, {tg, ti});
        chk({req, " op"}, alu_op_o, op);
        chk({req, " mem"}, {mem_ref_o, offset_o}, {mem, off});
    endtask

    task automatic t_reset();
        chk("R11 vld after reset", op_vld_o, 0);
        chk("R11 illegal after reset", illegal_o, 0);
        send(8'h3D);
        chk_alu("R11 reset context", 2'd0, 4'd0, 2'd0, 4'd3, 3'd3, 0, 8'h00);
    endtask

    task automatic t_alu();
        send(8'hA1); send(8'hAB); send(8'h2D);
        chk_alu("R3 or A1,B2", 2'd0, 4'd1, 2'd1, 4'd2, 3'd3, 0, 8'h00);
        send(8'h9A);
        chk_alu("R3 add", 2'd0, 4'd1, 2'd1, 4'd9, 3'd0, 0, 8'h00);
        send(8'h4E);
        chk_alu("R3 xor", 2'd0, 4'd1, 2'd1, 4'd4, 3'd4, 0, 8'h00);
    endtask

    task automatic t_select();
        send(8'hA1);
        chk("R4 select no record", op_vld_o, 0);
        send(8'hA2);
        chk("R4 select no record", op_vld_o, 0);
        send(8'hB7); send(8'h0F);
        chk_alu("R4 last select wins", 2'd1, 4'd7, 2'd1, 4'd0, 3'd5, 0, 8'h00);
    endtask

    task automatic t_pair();
        send(8'hA3); send(8'hCD);
        chk("R5 pair no record", op_vld_o, 0);
        send(8'h5F);
        chk_alu("R5 pair C,D", 2'd2, 4'd3, 2'd3, 4'd5, 3'd5, 0, 8'h00);
    endtask

    task automatic t_prefix();
        send(8'hAA); send(8'hA1); send(8'h67);
        chk("R2 prefix no record", op_vld_o, 0);
        chk("R2 prefix not illegal", illegal_o, 0);
        send(8'h8D);
        chk_alu("R8 prefix consumed", 2'd0, 4'd1, 2'd0, 4'd8, 3'd3, 1, 8'h67);
        send(8'h8D);
        chk_alu("R8 prefix cleared", 2'd0, 4'd1, 2'd0, 4'd8, 3'd3, 0, 8'h00);
    endtask

    task automatic t_halt();
        send(8'h00);
        chk("R1 halt vld", op_vld_o, 1);
        chk("R1 halt kind", op_kind_o, 0);
        chk("R1 halt no mem", mem_ref_o, 0);
        send(8'h42); send(8'h00);
        chk("R8 halt with prefix", {op_vld_o, op_kind_o, mem_ref_o, offset_o}, {1'b1, 2'd0, 1'b1, 8'h42});
    endtask

    task automatic t_cret();
        send(8'hCF);
        chk("R6 CF", {op_vld_o, op_kind_o, cond_o}, {1'b1, 2'd2, 3'd5});
        send(8'hAE);
        chk("R6 AE", {op_vld_o, op_kind_o, cond_o}, {1'b1, 2'd2, 3'd0});
        send(8'hBF);
        chk("R6 BF", {op_vld_o, op_kind_o, cond_o}, {1'b1, 2'd2, 3'd3});
        send(8'h07); send(8'hCE);
        chk("R6 CE with prefix", {op_vld_o, op_kind_o, cond_o, mem_ref_o, offset_o}, {1'b1, 2'd2, 3'd4, 1'b1, 8'h07});
    endtask

    task automatic t_call();
        send(8'hF1);
        chk("R7 call F1", {op_vld_o, op_kind_o, target_o}, {1'b1, 2'd3, 16'hF100});
        send(8'hE0);
        chk("R7 call E0", {op_vld_o, op_kind_o, target_o}, {1'b1, 2'd3, 16'hE000});
    endtask

    task automatic t_illegal();
        send(8'hAA); send(8'hA1);
        send(8'hDE);
        chk("R9 DE illegal", {illegal_o, op_vld_o}, 2'b10);
        send(8'hDF);
        chk("R9 DF illegal", {illegal_o, op_vld_o}, 2'b10);
        send(8'h1A);
        chk_alu("R9 context kept", 2'd0, 4'd1, 2'd0, 4'd1, 3'd0, 0, 8'h00);
        send(8'h12); send(8'h34);
        chk("R9 prefix on prefix", {illegal_o, op_vld_o}, 2'b10);
        send(8'h0A);
        chk_alu("R9 first prefix kept", 2'd0, 4'd1, 2'd0, 4'd0, 3'd0, 1, 8'h12);
        send(8'h12); send(8'hB5);
        chk("R9 select on prefix", {illegal_o, op_vld_o}, 2'b10);
        send(8'h3F);
        chk_alu("R9 select dropped", 2'd0, 4'd1, 2'd0, 4'd3, 3'd5, 1, 8'h12);
        send(8'h12); send(8'hCC);
        chk("R9 pair on prefix", {illegal_o, op_vld_o}, 2'b10);
        send(8'h3F);
        chk_alu("R9 pair dropped", 2'd0, 4'd1, 2'd0, 4'd3, 3'd5, 1, 8'h12);
    endtask

    task automatic t_idle();
        send(8'hF3);
        repeat (3) @(negedge clk);
        chk("R10 no pulse while idle", {op_vld_o, illegal_o}, 2'b00);
        chk("R10 record held", {op_kind_o, target_o}, {2'd3, 16'hF300});
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_alu();
        t_select();
        t_pair();
        t_prefix();
        t_halt();
        t_cret();
        t_call();
        t_illegal();
        t_idle();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++;
            nerr++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule